// File: doc/BRIEF.md
# Conditional Call and Return Stack Sequencer

This block is the multi-cycle control-transfer engine of a small 8-bit processor with a 16-bit address space. Once the opcode decoder has classified an instruction, it hands the sequencer an operation code, a condition selector, the zero and carry flags, and the current program counter, stack pointer and 16-bit register pair. The sequencer then performs absolute jumps, relative branches, calls, returns, interrupt returns, and register-pair pushes and pops. It moves one byte per cycle through a simple memory port and fetches immediate operand bytes from the program counter.

The condition is resolved in the cycle the operation is accepted. A branch that is not taken still fetches all of its operand bytes, so the program counter ends past them. Stack traffic goes byte by byte, and taken transfers, returns and pushes spend one extra settle cycle. When the operation finishes, the updated program counter, stack pointer and (for a pop) the loaded pair are presented together with a one-cycle done pulse. An interrupt return also raises a one-cycle interrupt-enable pulse. The memory is expected to answer a read in the same cycle: `mem_rdata` is sampled at the clock edge that ends the read cycle.

Top module: `callret_seq`

## Requirements
- R1: The condition selector `cond` is resolved from `flag_z`/`flag_c` in the accepting cycle: 0 always, 1 carry set, 2 zero set, 3 carry clear, 4 zero clear. Codes 5 to 7 act as always. Push, pop and interrupt return ignore the condition.
- R2: Absolute jump (`op`=0) reads the low target byte at PC and then the high byte at PC+1. If taken, PC becomes {high, low} and done arrives 3 edges after acceptance. Otherwise PC becomes PC+2 and done arrives after 2 edges.
- R3: Relative branch (`op`=1) reads one byte at PC. If taken, PC becomes PC+1 plus the sign-extended byte, with done after 2 edges. Otherwise PC becomes PC+1, with done after 1 edge.
- R4: A taken call (`op`=2) lowers SP by 2 and writes the low byte of PC+2 at the new SP and then its high byte at SP+1. It then reads both target bytes at PC and PC+1, and PC becomes {high, low}. Done arrives 5 edges after acceptance.
- R5: A call that is not taken performs no writes, still reads both operand bytes, and leaves PC at PC+2 and SP unchanged. Done arrives after 2 edges.
- R6: Return (`op`=3) reads the low byte at SP. If taken, it reads the high byte at SP+1, PC becomes {high, low} and SP becomes SP+2, with done after 3 edges. If not taken, only the first read happens and PC and SP stay unchanged, with done after 1 edge.
- R7: Interrupt return (`op`=4) behaves as a taken return whatever the condition, and `irq_en` is high in exactly the cycle `done` is high. No other operation raises `irq_en`.
- R8: Push (`op`=5) writes the pair's high byte at SP-1 and then its low byte at SP-2, and leaves SP at SP-2. Done arrives 3 edges after acceptance.
- R9: Pop (`op`=6) reads the low byte at SP and the high byte at SP+1. It presents {high, low} on `pair_out` with `pair_load` high in the done cycle only, and leaves SP at SP+2. Done arrives after 2 edges.
- R10: All PC, SP and address arithmetic wraps modulo 2^16.
- R11: After reset the block is idle with all outputs zero. A start is accepted only while `busy` is low, and a start during an operation has no effect. `done` is a single-cycle pulse with `busy` low. The read and write strobes are never high together and are both low while idle.
- R12: A start with `op`=7 is ignored: the block stays idle, no done appears and the PC output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | Operation code |
| cond | input | 3 | Condition selector |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| pc_in | input | 16 | Program counter, pointing at the first operand byte |
| sp_in | input | 16 | Stack pointer |
| pair_in | input | 16 | Register pair for push |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid in the read cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 16 | Updated stack pointer |
| pair_out | output | 16 | Pair loaded by pop |
| pair_load | output | 1 | Pair valid pulse (pop) |
| irq_en | output | 1 | Interrupt-enable pulse (interrupt return) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |

## Verification
A wrong step in the state sequence shows up at once as a strobe in the wrong cycle or at the wrong address. It also shifts the done pulse by at least one edge, so the bench measures every operation's latency exactly and logs every write address and byte. A condition captured wrongly, or a stack pointer stepped the wrong way, appears at the done cycle as a program counter or stack pointer that differs from the arithmetic expectation. Sweeping all condition codes against all four flag combinations shows this for each control-transfer kind, and the wrap cases show it for arithmetic that does not wrap modulo 2^16.

// File: rtl/csq_pkg.sv
package csq_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_JUMP   = 3'd0,
        OP_BRANCH = 3'd1,
        OP_CALL   = 3'd2,
        OP_RET    = 3'd3,
        OP_RETI   = 3'd4,
        OP_PUSH   = 3'd5,
        OP_POP    = 3'd6,
        OP_NONE   = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        CND_ALWAYS = 3'd0,
        CND_CSET   = 3'd1,
        CND_ZSET   = 3'd2,
        CND_CCLR   = 3'd3,
        CND_ZCLR   = 3'd4
    } cnd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IMM_LO,
        ST_IMM_HI,
        ST_CALL_WLO,
        ST_CALL_WHI,
        ST_STK_RLO,
        ST_STK_RHI,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_SETTLE
    } st_e;

endpackage

// File: rtl/csq_cond.sv
module csq_cond
    import csq_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       zf,
    input  logic       cf,
    output logic       take
);
    always_comb begin
        case (sel)
            CND_CSET: take = cf;
            CND_ZSET: take = zf;
            CND_CCLR: take = ~cf;
            CND_ZCLR: take = ~zf;
            default:  take = 1'b1;
        endcase
    end
endmodule

// File: rtl/csq_arith.sv
module csq_arith #(
    parameter int DW = csq_pkg::BYTE_W
) (
    input  logic [2*DW-1:0] pc,
    input  logic [2*DW-1:0] sp,
    input  logic [DW-1:0]   rel,
    output logic [2*DW-1:0] pc_inc,
    output logic [2*DW-1:0] pc_rel,
    output logic [2*DW-1:0] ret_addr,
    output logic [2*DW-1:0] sp_inc,
    output logic [2*DW-1:0] sp_dec
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] rel_ext;

    always_comb begin
        rel_ext  = {{(AW-DW){rel[DW-1]}}, rel};
        pc_inc   = pc + AW'(1);
        pc_rel   = pc + rel_ext;
        ret_addr = pc + AW'(2);
        sp_inc   = sp + AW'(1);
        sp_dec   = sp - AW'(1);
    end
endmodule

// File: rtl/csq_memport.sv
module csq_memport
    import csq_pkg::*;
#(
    parameter int DW = csq_pkg::BYTE_W
) (
    input  st_e             state,
    input  logic [2*DW-1:0] pc,
    input  logic [2*DW-1:0] sp,
    input  logic [2*DW-1:0] sp_inc,
    input  logic [2*DW-1:0] sp_dec,
    input  logic [2*DW-1:0] ret_addr,
    input  logic [2*DW-1:0] pair,
    output logic [2*DW-1:0] addr,
    output logic [DW-1:0]   wdata,
    output logic            rd,
    output logic            wr
);
    localparam int AW = 2 * DW;

    always_comb begin
        addr  = '0;
        wdata = '0;
        rd    = 1'b0;
        wr    = 1'b0;
        case (state)
            ST_IMM_LO, ST_IMM_HI: begin
                rd   = 1'b1;
                addr = pc;
            end
            ST_CALL_WLO: begin
                wr    = 1'b1;
                addr  = sp;
                wdata = ret_addr[DW-1:0];
            end
            ST_CALL_WHI: begin
                wr    = 1'b1;
                addr  = sp_inc;
                wdata = ret_addr[AW-1:DW];
            end
            ST_STK_RLO, ST_STK_RHI: begin
                rd   = 1'b1;
                addr = sp;
            end
            ST_PUSH_HI: begin
                wr    = 1'b1;
                addr  = sp_dec;
                wdata = pair[AW-1:DW];
            end
            ST_PUSH_LO: begin
                wr    = 1'b1;
                addr  = sp_dec;
                wdata = pair[DW-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/callret_seq.sv
module callret_seq
    import csq_pkg::*;
#(
    parameter int DW = csq_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [2:0]        cond,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [2*DW-1:0]   pc_in,
    input  logic [2*DW-1:0]   sp_in,
    input  logic [2*DW-1:0]   pair_in,
    output logic [2*DW-1:0]   mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [2*DW-1:0]   pc_out,
    output logic [2*DW-1:0]   sp_out,
    output logic [2*DW-1:0]   pair_out,
    output logic              pair_load,
    output logic              irq_en,
    output logic              busy,
    output logic              done
);
    localparam int AW = 2 * DW;

    typedef struct packed {
        st_e           st;
        op_e           op;
        logic          take;
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [AW-1:0] pair;
        logic [DW-1:0] lo;
        logic          done;
        logic          pload;
        logic          ie;
    } regs_t;

    regs_t r_d, r_q;

    op_e           op_new;
    logic          cond_ok;
    logic [AW-1:0] pc_inc, pc_rel, ret_addr, sp_inc, sp_dec;

    assign op_new = op_e'(op);

    csq_cond u_cond (
        .sel  (cond),
        .zf   (flag_z),
        .cf   (flag_c),
        .take (cond_ok)
    );

    csq_arith #(.DW(DW)) u_arith (
        .pc       (r_q.pc),
        .sp       (r_q.sp),
        .rel      (r_q.lo),
        .pc_inc   (pc_inc),
        .pc_rel   (pc_rel),
        .ret_addr (ret_addr),
        .sp_inc   (sp_inc),
        .sp_dec   (sp_dec)
    );

    csq_memport #(.DW(DW)) u_memport (
        .state    (r_q.st),
        .pc       (r_q.pc),
        .sp       (r_q.sp),
        .sp_inc   (sp_inc),
        .sp_dec   (sp_dec),
        .ret_addr (ret_addr),
        .pair     (r_q.pair),
        .addr     (mem_addr),
        .wdata    (mem_wdata),
        .rd       (mem_rd),
        .wr       (mem_wr)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.pload = 1'b0;
        r_d.ie    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start && op_new != OP_NONE) begin
                    r_d.op   = op_new;
                    r_d.pc   = pc_in;
                    r_d.sp   = sp_in;
                    r_d.pair = pair_in;
                    if (op_new == OP_RETI || op_new == OP_PUSH || op_new == OP_POP)
                        r_d.take = 1'b1;
                    else
                        r_d.take = cond_ok;
                    case (op_new)
                        OP_JUMP, OP_BRANCH: r_d.st = ST_IMM_LO;
                        OP_CALL: begin
                            if (cond_ok) begin
                                r_d.sp = sp_in - AW'(2);
                                r_d.st = ST_CALL_WLO;
                            end else begin
                                r_d.st = ST_IMM_LO;
                            end
                        end
                        OP_RET, OP_RETI, OP_POP: r_d.st = ST_STK_RLO;
                        OP_PUSH: r_d.st = ST_PUSH_HI;
                        default: r_d.st = ST_IDLE;
                    endcase
                end
            end
            ST_IMM_LO: begin
                r_d.lo = mem_rdata;
                r_d.pc = pc_inc;
                if (r_q.op == OP_BRANCH) begin
                    if (r_q.take) begin
                        r_d.st = ST_SETTLE;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end else begin
                    r_d.st = ST_IMM_HI;
                end
            end
            ST_IMM_HI: begin
                if (r_q.take) begin
                    r_d.pc = {mem_rdata, r_q.lo};
                    r_d.st = ST_SETTLE;
                end else begin
                    r_d.pc   = pc_inc;
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            ST_CALL_WLO: r_d.st = ST_CALL_WHI;
            ST_CALL_WHI: r_d.st = ST_IMM_LO;
            ST_STK_RLO: begin
                r_d.lo = mem_rdata;
                if (!r_q.take) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.sp = sp_inc;
                    r_d.st = ST_STK_RHI;
                end
            end
            ST_STK_RHI: begin
                r_d.sp = sp_inc;
                if (r_q.op == OP_POP) begin
                    r_d.pair  = {mem_rdata, r_q.lo};
                    r_d.pload = 1'b1;
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.pc = {mem_rdata, r_q.lo};
                    r_d.st = ST_SETTLE;
                end
            end
            ST_PUSH_HI: begin
                r_d.sp = sp_dec;
                r_d.st = ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
                r_d.sp = sp_dec;
                r_d.st = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (r_q.op == OP_BRANCH)
                    r_d.pc = pc_rel;
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
                r_d.ie   = (r_q.op == OP_RETI);
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign pc_out    = r_q.pc;
    assign sp_out    = r_q.sp;
    assign pair_out  = r_q.pair;
    assign pair_load = r_q.pload;
    assign irq_en    = r_q.ie;
    assign done      = r_q.done;
    assign busy      = (r_q.st != ST_IDLE);

endmodule

// File: rtl/csq_chk.sv
module csq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] op,
    input logic       busy,
    input logic       done,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       irq_en,
    input logic       pair_load
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R11

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R11

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_wr)); // R11

    AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op != 3'd7) |=> busy); // R11

    AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op == 3'd7) |=> (!busy && !done)); // R12

    AST_IE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en |-> done); // R7

    AST_LOAD_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_load |-> (done && !irq_en)); // R9
endmodule

bind callret_seq csq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .busy      (busy),
    .done      (done),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .irq_en    (irq_en),
    .pair_load (pair_load)
);

// File: tb/callret_seq_tb.sv
`timescale 1ns/1ps
module callret_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [2:0]  cond = 3'd0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic [15:0] pc_in = 16'd0;
    logic [15:0] sp_in = 16'd0;
    logic [15:0] pair_in = 16'd0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_rd, mem_wr;
    logic [15:0] pc_out, sp_out, pair_out;
    logic        pair_load, irq_en, busy, done;

    always #2 clk = ~clk;

    callret_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond(cond),
        .flag_z(flag_z), .flag_c(flag_c), .pc_in(pc_in), .sp_in(sp_in),
        .pair_in(pair_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .pc_out(pc_out), .sp_out(sp_out), .pair_out(pair_out),
        .pair_load(pair_load), .irq_en(irq_en), .busy(busy), .done(done)
    );

    logic [7:0]  mem [256];
    assign mem_rdata = mem[mem_addr[7:0]];

    int          checks = 0;
    int          errors = 0;
    int          wr_total = 0;
    logic [15:0] wa [16];
    logic [7:0]  wd [16];

    always @(posedge clk) begin
        if (rst_n && mem_wr) begin
            wa[wr_total % 16] <= mem_addr;
            wd[wr_total % 16] <= mem_wdata;
            wr_total <= wr_total + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [2:0] o, input logic [2:0] cs,
                            input logic fz, input logic fc,
                            input logic [15:0] pc, input logic [15:0] sp,
                            input logic [15:0] pr,
                            input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] s0, input logic [7:0] s1,
                            input string req);
        logic        tk;
        logic [15:0] e_pc, e_sp, e_pair, ra, p1, sp1;
        logic [15:0] e_wa [2];
        logic [7:0]  e_wd [2];
        logic        e_ie, e_pl;
        int          e_steps, e_nw, cnt, base;
        p1  = pc + 16'd1;
        sp1 = sp + 16'd1;
        mem[pc[7:0]]  = b0;
        mem[p1[7:0]]  = b1;
        mem[sp[7:0]]  = s0;
        mem[sp1[7:0]] = s1;
        case (cs)
            3'd1:    tk = fc;
            3'd2:    tk = fz;
            3'd3:    tk = !fc;
            3'd4:    tk = !fz;
            default: tk = 1'b1;
        endcase
        e_pc = pc; e_sp = sp; e_pair = pr; e_nw = 0; e_ie = 1'b0; e_pl = 1'b0;
        e_steps = 0; ra = pc + 16'd2;
        e_wa[0] = 16'd0; e_wa[1] = 16'd0; e_wd[0] = 8'd0; e_wd[1] = 8'd0;
        case (o)
            3'd0: begin
                if (tk) begin e_pc = {b1, b0}; e_steps = 3; end
                else    begin e_pc = pc + 16'd2; e_steps = 2; end
            end
            3'd1: begin
                if (tk) begin e_pc = pc + 16'd1 + {{8{b0[7]}}, b0}; e_steps = 2; end
                else    begin e_pc = pc + 16'd1; e_steps = 1; end
            end
            3'd2: begin
                if (tk) begin
                    e_sp = sp - 16'd2; e_nw = 2;
                    e_wa[0] = sp - 16'd2; e_wd[0] = ra[7:0];
                    e_wa[1] = sp - 16'd1; e_wd[1] = ra[15:8];
                    e_pc = {b1, b0}; e_steps = 5;
                end else begin
                    e_pc = pc + 16'd2; e_steps = 2;
                end
            end
            3'd3: begin
                if (tk) begin e_pc = {s1, s0}; e_sp = sp + 16'd2; e_steps = 3; end
                else    begin e_steps = 1; end
            end
            3'd4: begin
                e_pc = {s1, s0}; e_sp = sp + 16'd2; e_steps = 3; e_ie = 1'b1;
            end
            3'd5: begin
                e_sp = sp - 16'd2; e_nw = 2; e_steps = 3;
                e_wa[0] = sp - 16'd1; e_wd[0] = pr[15:8];
                e_wa[1] = sp - 16'd2; e_wd[1] = pr[7:0];
            end
            default: begin
                e_pair = {s1, s0}; e_sp = sp + 16'd2; e_pl = 1'b1; e_steps = 2;
            end
        endcase
        @(negedge clk);
        start = 1'b1; op = o; cond = cs; flag_z = fz; flag_c = fc;
        pc_in = pc; sp_in = sp; pair_in = pr;
        base = wr_total;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        chk(req, "latency", cnt, e_steps);
        chk(req, "pc_out", {16'd0, pc_out}, {16'd0, e_pc});
        chk(req, "sp_out", {16'd0, sp_out}, {16'd0, e_sp});
        chk("R7", "irq_en", {31'd0, irq_en}, {31'd0, e_ie});
        chk("R9", "pair_load", {31'd0, pair_load}, {31'd0, e_pl});
        chk("R11", "busy at done", {31'd0, busy}, 32'd0);
        if (o == 3'd6)
            chk(req, "pair_out", {16'd0, pair_out}, {16'd0, e_pair});
        chk(req, "write count", wr_total - base, e_nw);
        for (int k = 0; k < e_nw; k++) begin
            chk(req, "write addr", {16'd0, wa[(base + k) % 16]}, {16'd0, e_wa[k]});
            chk(req, "write data", {24'd0, wd[(base + k) % 16]}, {24'd0, e_wd[k]});
        end
        @(negedge clk);
        chk("R11", "done width", {31'd0, done}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'd0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "reset busy", {31'd0, busy}, 32'd0);
        chk("R11", "reset done", {31'd0, done}, 32'd0);
        chk("R11", "reset strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
        chk("R11", "reset pc/sp", {pc_out, sp_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 sweep over condition codes and flags for each conditional kind
        for (int o = 0; o < 4; o++) begin
            for (int cs = 0; cs < 8; cs++) begin
                for (int f = 0; f < 4; f++) begin
                    automatic int idx = o * 32 + cs * 4 + f;
                    automatic logic [15:0] pcv = {8'h30 + idx[7:0], 8'h20};
                    automatic string rq = (o == 0) ? "R1 R2" : (o == 1) ? "R1 R3" :
                                          (o == 2) ? "R1 R4 R5" : "R1 R6";
                    run_case(o[2:0], cs[2:0], f[1], f[0], pcv, 16'h8090,
                             16'h1234 ^ idx[15:0],
                             8'(idx * 37 + 3), 8'(idx * 11 + 65),
                             8'(idx * 7 + 85), 8'hA0 ^ idx[7:0], rq);
                end
            end
        end

        // R7: interrupt return ignores the condition
        for (int f = 0; f < 4; f++)
            run_case(3'd4, 3'd3, f[1], 1'b1, 16'h4420, 16'h8090, 16'h0,
                     8'h00, 8'h00, 8'h3C + f[7:0], 8'h5A, "R7");

        // R8 / R9: push and pop with several values
        run_case(3'd5, 3'd1, 1'b0, 1'b0, 16'h4420, 16'h8090, 16'hBEEF,
                 8'h0, 8'h0, 8'h0, 8'h0, "R8");
        run_case(3'd5, 3'd0, 1'b1, 1'b1, 16'h4420, 16'hC0A0, 16'h0102,
                 8'h0, 8'h0, 8'h0, 8'h0, "R8");
        run_case(3'd6, 3'd4, 1'b1, 1'b0, 16'h4420, 16'h8090, 16'h0,
                 8'h0, 8'h0, 8'h7E, 8'hC3, "R9");
        run_case(3'd6, 3'd0, 1'b0, 1'b0, 16'h4420, 16'hC0A0, 16'hFFFF,
                 8'h0, 8'h0, 8'h01, 8'h80, "R9");

        // R10: wrap-around cases
        run_case(3'd2, 3'd0, 1'b0, 1'b0, 16'h2040, 16'h0001, 16'h0,
                 8'h11, 8'h22, 8'h0, 8'h0, "R10 R4");
        run_case(3'd3, 3'd0, 1'b0, 1'b0, 16'h2040, 16'hFFFF, 16'h0,
                 8'h0, 8'h0, 8'h34, 8'h12, "R10 R6");
        run_case(3'd1, 3'd0, 1'b0, 1'b0, 16'hFFFE, 16'h5080, 16'h0,
                 8'h05, 8'h0, 8'h0, 8'h0, "R10 R3");
        run_case(3'd1, 3'd0, 1'b0, 1'b0, 16'h0005, 16'h5080, 16'h0,
                 8'h80, 8'h0, 8'h0, 8'h0, "R10 R3");
        run_case(3'd5, 3'd0, 1'b0, 1'b0, 16'h2040, 16'h0000, 16'hA55A,
                 8'h0, 8'h0, 8'h0, 8'h0, "R10 R8");
        run_case(3'd6, 3'd0, 1'b0, 1'b0, 16'h2040, 16'hFFFF, 16'h0,
                 8'h0, 8'h0, 8'h99, 8'h77, "R10 R9");
        run_case(3'd0, 3'd3, 1'b0, 1'b1, 16'hFFFF, 16'h5080, 16'h0,
                 8'h12, 8'h34, 8'h0, 8'h0, "R10 R2");

        // R11: a start while busy has no effect
        begin
            int cnt, base, extra;
            base = wr_total;
            @(negedge clk);
            start = 1'b1; op = 3'd5; cond = 3'd0; pc_in = 16'h6600;
            sp_in = 16'h9000; pair_in = 16'h4321;
            @(negedge clk);
            op = 3'd0; pc_in = 16'h7700; sp_in = 16'h1000;
            cnt = 0;
            while (!done && cnt < 40) begin
                @(negedge clk);
                cnt++;
                if (cnt == 2) start = 1'b0;
            end
            start = 1'b0;
            chk("R11", "busy-start latency", cnt, 3);
            chk("R11", "busy-start sp", {16'd0, sp_out}, 32'h8FFE);
            chk("R11", "busy-start pc", {16'd0, pc_out}, 32'h6600);
            chk("R11", "busy-start writes", wr_total - base, 2);
            extra = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            chk("R11", "no second operation", extra, 0);
        end

        // R12: reserved operation code is ignored
        begin
            logic [15:0] prev;
            int seen;
            prev = pc_out;
            @(negedge clk);
            start = 1'b1; op = 3'd7; pc_in = 16'hDEAD;
            @(negedge clk);
            start = 1'b0;
            seen = 0;
            for (int k = 0; k < 5; k++) begin
                if (busy || done || mem_rd || mem_wr) seen++;
                @(negedge clk);
            end
            chk("R12", "reserved activity", seen, 0);
            chk("R12", "reserved pc kept", {16'd0, pc_out}, {16'd0, prev});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule